// File: doc/BRIEF.md
# UART Interrupt State Logic

This block keeps the interrupt bookkeeping of a UART peripheral. Four sources report to it as single-cycle event pulses from the datapath. Each pulse latches a sticky state bit. A per-source enable mask gates the state bits onto four level interrupt lines. Software reaches the block through a plain 32-bit register port with a word address, a write strobe, write data and combinational read data.

Software clears pending bits by writing ones to the state register. It sets the enable mask by writing the enable register whole. A write-only test register lets software force any state bit high, so interrupt handlers can be exercised without real traffic. When a hardware event and a software clear land on the same bit in the same cycle, the event wins, so no event is lost.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset, the state and enable registers are zero and all four interrupt outputs are low.
- R2: Interrupt output bit i is high exactly when state bit i and enable bit i are both set. It follows the registers from the clock edge that changes them. Bit order is 0 TX watermark, 1 RX watermark, 2 TX empty, 3 RX overflow.
- R3: A pulse on evtPulse[i] sets state bit i at the next clock edge. The bit stays set until software clears it.
- R4: A write to word offset 0 (state) clears every state bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A write to word offset 2 (test) ORs write-data bits 3:0 into the state register.
- R6: A read of word offset 2 returns zero.
- R7: A write to word offset 1 (enable) replaces the whole enable mask with write-data bits 3:0.
- R8: If an event pulse and a clearing write hit the same state bit in one cycle, the bit ends up set.
- R9: Read data bits 31:4 are always zero, and write-data bits 31:4 have no effect.
- R10: Offsets other than 0, 1 and 2 read as zero, and writes to them change nothing.
- R11: Reads of offsets 0 and 1 return the current state and enable values and change neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtPulse | input | 4 | One-cycle event pulses from the datapath, one per source |
| regAddr | input | 4 | Word address of the register access |
| regWe | input | 1 | Write strobe, sampled at the clock edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| irqOut | output | 4 | Level interrupt lines, state AND enable |

## Verification
Every register write and every event pulse takes effect at the first rising edge that samples it. The interrupt lines are a direct function of the two registers, so they are due in the same cycle as the register update. Read data needs no clock: it is due as soon as the address settles. The bench therefore drives inputs on a falling edge and checks the interrupt lines on the next falling edge, after exactly one rising edge. It checks reads one nanosecond after it moves the address, with no rising edge in between.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] OFF_STATE  = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_TEST   = 4'd2;

  typedef struct packed {
    logic wrState;
    logic wrEnable;
    logic wrTest;
    logic rdState;
    logic rdEnable;
  } irq_strobe_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output irq_strobe_t       strobe
);
  logic hitState, hitEnable, hitTest;

  always_comb begin
    hitState  = (regAddr == OFF_STATE);
    hitEnable = (regAddr == OFF_ENABLE);
    hitTest   = (regAddr == OFF_TEST);
    strobe.wrState  = regWe & hitState;
    strobe.wrEnable = regWe & hitEnable;
    strobe.wrTest   = regWe & hitTest;
    strobe.rdState  = hitState;
    strobe.rdEnable = hitEnable;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  irq_strobe_t        strobe,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] evtPulse,
  output logic [NUM_SRC-1:0] stateQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic [NUM_SRC-1:0] irqOut
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic bitQ;
    logic setReq, clrReq;
    assign setReq = evtPulse[i] | (strobe.wrTest & wdata[i]);
    assign clrReq = strobe.wrState & wdata[i];

    always_ff @(posedge clk) begin
      if (!rst_n)      bitQ <= 1'b0;
      else if (setReq) bitQ <= 1'b1;   // set has priority over clear
      else if (clrReq) bitQ <= 1'b0;
    end
    assign stateQ[i] = bitQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               enQ <= '0;
    else if (strobe.wrEnable) enQ <= wdata;
  end

  assign irqOut = stateQ & enQ;
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_SRC-1:0] irqOut
);
  irq_strobe_t        strobe;
  logic [NUM_SRC-1:0] stateQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] rdLow;
  logic               unusedWdataHi;

  assign unusedWdataHi = ^regWdata[DATA_W-1:NUM_SRC];

  uart_irq_ctrl ctrl_i (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  uart_irq_dp dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wdata    (regWdata[NUM_SRC-1:0]),
    .evtPulse (evtPulse),
    .stateQ   (stateQ),
    .enQ      (enQ),
    .irqOut   (irqOut)
  );

  always_comb begin
    if (strobe.rdState)       rdLow = stateQ;
    else if (strobe.rdEnable) rdLow = enQ;
    else                      rdLow = '0;
    regRdata = {{(DATA_W-NUM_SRC){1'b0}}, rdLow};
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWe,
  input logic [DATA_W-1:0]  regWdata,
  input logic [DATA_W-1:0]  regRdata,
  input logic [NUM_SRC-1:0] irqOut,
  input logic [NUM_SRC-1:0] stateQ,
  input logic [NUM_SRC-1:0] enQ
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (stateQ == '0 && enQ == '0));

  assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut & ~enQ) == '0 && (irqOut & ~stateQ) == '0);

  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evtPulse != '0 |=> (stateQ & $past(evtPulse)) == $past(evtPulse));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == OFF_STATE && evtPulse == '0)
      |=> stateQ == ($past(stateQ) & ~$past(regWdata[NUM_SRC-1:0])));

  assert_test_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == OFF_TEST)
      |=> (stateQ & $past(regWdata[NUM_SRC-1:0])) == $past(regWdata[NUM_SRC-1:0]));

  assert_test_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    regAddr == OFF_TEST |-> regRdata == '0);

  assert_enable_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == OFF_ENABLE) |=> enQ == $past(regWdata[NUM_SRC-1:0]));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    regRdata[DATA_W-1:NUM_SRC] == '0);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!regWe && evtPulse == '0) |=> ($stable(stateQ) && $stable(enQ)));
endmodule

bind uart_irq_regs uart_irq_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .evtPulse (evtPulse),
  .regAddr  (regAddr),
  .regWe    (regWe),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .irqOut   (irqOut),
  .stateQ   (stateQ),
  .enQ      (enQ)
);

// File: tb/uart_irq_regs_tb.sv
module uart_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evtPulse = '0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  uart_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  // vector: addr[20:17] we[16] wdata[15:8] evt[7:4] expIrq[3:0]
  localparam int NVEC = 14;
  localparam logic [20:0] VEC [NVEC] = '{
    {4'd1, 1'b1, 8'h0F, 4'h0, 4'h0},  // R7 enable all
    {4'd0, 1'b0, 8'h00, 4'h1, 4'h1},  // R3 TX watermark event
    {4'd0, 1'b0, 8'h00, 4'h4, 4'h5},  // R3 TX empty event, sticky
    {4'd0, 1'b1, 8'h01, 4'h0, 4'h4},  // R4 clear bit 0
    {4'd2, 1'b1, 8'h0A, 4'h0, 4'hE},  // R5 force bits 1,3
    {4'd1, 1'b1, 8'h03, 4'h0, 4'h2},  // R7 mask replaced, R2
    {4'd0, 1'b1, 8'hFF, 4'h2, 4'h2},  // R8 set beats clear
    {4'd1, 1'b1, 8'h0C, 4'h0, 4'h0},  // R2 masked
    {4'd0, 1'b0, 8'h00, 4'h8, 4'h8},  // R3 overflow event
    {4'd2, 1'b1, 8'hF0, 4'h0, 4'h8},  // R9 upper data ignored
    {4'd0, 1'b1, 8'h0A, 4'h0, 4'h0},  // R4 clear all pending
    {4'd3, 1'b1, 8'h0F, 4'h0, 4'h0},  // R10 unmapped write
    {4'd1, 1'b1, 8'hFF, 4'h0, 4'h0},  // R7 enable all again
    {4'd2, 1'b1, 8'h05, 4'h0, 4'h5}   // R5 force bits 0,2
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] e);
    regAddr = a; regWe = 1'b1; regWdata = d; evtPulse = e;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; evtPulse = '0;
  endtask

  task automatic pulse(input logic [3:0] e);
    evtPulse = e;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic readChk(input string req, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  initial begin : watchdog
    #1000000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {28'h0, irqOut}, 32'h0);
    readChk("R1 state", 4'd0, 32'h0);
    readChk("R1 enable", 4'd1, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      regAddr = VEC[i][20:17];
      regWe = VEC[i][16];
      regWdata = {24'h0, VEC[i][15:8]};
      evtPulse = VEC[i][7:4];
      @(negedge clk);
      regWe = 1'b0; regWdata = '0; evtPulse = '0;
      check($sformatf("R2 vector %0d irq", i), {28'h0, irqOut}, {28'h0, VEC[i][3:0]});
    end

    // state now 5, enable F
    readChk("R11 state read", 4'd0, 32'h5);
    readChk("R11 state read no side effect", 4'd0, 32'h5);
    readChk("R11 enable read", 4'd1, 32'hF);
    readChk("R6 test reads zero", 4'd2, 32'h0);
    readChk("R10 unmapped reads zero", 4'd3, 32'h0);
    readChk("R10 high offset reads zero", 4'd15, 32'h0);

    // R9 high write bits ignored, high read bits zero
    doWrite(4'd1, 32'hFFFF_FFF0, 4'h0);
    readChk("R9 enable upper ignored", 4'd1, 32'h0);
    check("R2 irq off with mask 0", {28'h0, irqOut}, 32'h0);
    doWrite(4'd1, 32'hFFFF_FFFF, 4'h0);
    readChk("R9 enable read upper zero", 4'd1, 32'hF);

    // R10 unmapped write leaves state alone
    doWrite(4'd7, 32'hF, 4'h0);
    readChk("R10 state untouched", 4'd0, 32'h5);

    // R8 set beats clear on every bit at once
    doWrite(4'd0, 32'hF, 4'hF);
    readChk("R8 all set after collision", 4'd0, 32'hF);
    check("R8 irq all", {28'h0, irqOut}, 32'hF);

    // R4 partial clear keeps others
    doWrite(4'd0, 32'h6, 4'h0);
    readChk("R4 partial clear", 4'd0, 32'h9);

    // R3 event while idle on other bit, sticky across cycles
    pulse(4'h2);
    @(negedge clk);
    readChk("R3 sticky", 4'd0, 32'hB);

    // R5 test write does not clear
    doWrite(4'd2, 32'h0, 4'h0);
    readChk("R5 zero test write keeps state", 4'd0, 32'hB);

    // R1 reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {28'h0, irqOut}, 32'h0);
    readChk("R1 state after reset", 4'd0, 32'h0);
    readChk("R1 enable after reset", 4'd1, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule